// File: doc/BRIEF.md
# Bus bit-phase timing generator

This block derives the bit timing for a half-duplex shared serial bus. A programmable divider counts system clock cycles and produces a tick at the end of every half-period. Each tick flips a phase flag, so a bit cell is a positive half followed by a negative half. The transmitter launches each new bit on a one-cycle strobe at the start of every positive half. The receiver samples the line on a one-cycle strobe at the start of every negative half.

The block can align itself once to a remote transmitter. While it is not synced, the first falling edge seen on the receive input forces a positive half to start there, and the synced status is set. Later edges are ignored until the rearm input is pulsed. The receive input must already be synchronised to the system clock.

Top module: `bit_phase_timer`

## Requirements
- R1: The half-period H is the 16-bit `half_period_i` value in clock cycles, and a value of 0 counts as 1. Without a resync, consecutive strobes are exactly H cycles apart.
- R2: `phase_o` changes only at the end of a half-period or on a resync. It alternates positive (1) and negative (0) on successive half-periods.
- R3: `tx_strobe_o` is high for one cycle: the first cycle of each positive half. It is never high while `phase_o` is 0.
- R4: `sample_strobe_o` is high for one cycle: the first cycle of each negative half. It is never high while `phase_o` is 1.
- R5: While `synced_o` is 0, a falling edge on `rx_i` restarts the timing. An edge is `rx_i` sampled 1 at one clock edge and 0 at the next. In the cycle after the edge is sampled, `phase_o`=1, `tx_strobe_o`=1 and `synced_o`=1, and the next sample strobe comes H cycles after that tx strobe.
- R6: While `synced_o` is 1 and `rearm_i` is low, falling edges on `rx_i` do not change `phase_o`, the strobes or the spacing of the strobes, and `synced_o` stays 1.
- R7: A cycle with `rearm_i` high clears `synced_o` in the next cycle. An edge in the same cycle as rearm is ignored. A falling edge after rearm resyncs as in R5.
- R8: After reset, `phase_o`, both strobes and `synced_o` are 0. The first tx strobe appears H cycles after reset is released.
- R9: If H is lowered below the count already reached in the current half, that half ends at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_period_i | input | 16 | Half-bit period in clock cycles (0 treated as 1) |
| rearm_i | input | 1 | Clears synced status and re-enables edge resync |
| rx_i | input | 1 | Synchronised receive data, idle high |
| phase_o | output | 1 | 1 in the positive half, 0 in the negative half |
| tx_strobe_o | output | 1 | One-cycle pulse at the start of a positive half |
| sample_strobe_o | output | 1 | One-cycle pulse at the start of a negative half |
| synced_o | output | 1 | Set by the resync edge, cleared by rearm or reset |

## Verification
The divider is run with half-periods of 4, 7, 1 and 0. These show whether the count is exact and whether a zero value is clamped or wraps to a huge period. Falling edges are applied in mid-half at three points: unsynced, synced, and in the same cycle as rearm. This separates a working one-shot alignment from one that keeps realigning or one that never aligns. A drop of the half-period partway through a count shows whether the counter compares for overrun or runs on past the new limit.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int unsigned CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  // Effective half-period: zero is clamped to one cycle.
  function automatic cnt_t eff_period(input cnt_t raw);
    return (raw == '0) ? cnt_t'(1) : raw;
  endfunction
endpackage

// File: rtl/bpt_tick_div.sv
module bpt_tick_div
  import bpt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t period_i,
  input  logic force_i,
  output logic tick_o
);
  cnt_t cnt_q, cnt_d;
  cnt_t limit;
  logic cnt_en;

  always_comb begin
    limit  = eff_period(period_i) - cnt_t'(1);
    tick_o = !force_i && (cnt_q >= limit);
    cnt_en = 1'b1;
    if (force_i || tick_o) cnt_d = '0;
    else                   cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/bpt_phase_gen.sv
module bpt_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic force_i,
  output logic phase_o,
  output logic tx_o,
  output logic smp_o
);
  logic phase_q, phase_d;
  logic tx_q, tx_d;
  logic smp_q, smp_d;

  always_comb begin
    phase_d = phase_q;
    tx_d    = 1'b0;
    smp_d   = 1'b0;
    if (force_i) begin
      phase_d = 1'b1;
      tx_d    = 1'b1;
    end else if (tick_i) begin
      phase_d = !phase_q;
      tx_d    = !phase_q;
      smp_d   = phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      tx_q    <= 1'b0;
      smp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tx_q    <= tx_d;
      smp_q   <= smp_d;
    end
  end

  assign phase_o = phase_q;
  assign tx_o    = tx_q;
  assign smp_o   = smp_q;

  AST_TX_IN_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q |-> phase_q); // R3
  AST_SMP_IN_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_q |-> !phase_q); // R4
  AST_TOGGLE_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (tx_q || smp_q)); // R2
endmodule

// File: rtl/bpt_edge_lock.sv
module bpt_edge_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic rearm_i,
  output logic force_o,
  output logic synced_o
);
  logic rx_q;
  logic synced_q, synced_d;
  logic fall;

  always_comb begin
    fall     = rx_q && !rx_i;
    force_o  = fall && !synced_q && !rearm_i;
    synced_d = synced_q;
    if (rearm_i)      synced_d = 1'b0;
    else if (force_o) synced_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q     <= 1'b1;
      synced_q <= 1'b0;
    end else begin
      rx_q     <= rx_i;
      synced_q <= synced_d;
    end
  end

  assign synced_o = synced_q;

  AST_RESYNC_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> !synced_q); // R5
  AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_q && !rearm_i) |=> synced_q); // R6
  AST_REARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !synced_q); // R7
endmodule

// File: rtl/bit_phase_timer.sv
module bit_phase_timer
  import bpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_period_i,
  input  logic             rearm_i,
  input  logic             rx_i,
  output logic             phase_o,
  output logic             tx_strobe_o,
  output logic             sample_strobe_o,
  output logic             synced_o
);
  logic resync;
  logic tick;

  bpt_edge_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_i),
    .rearm_i  (rearm_i),
    .force_o  (resync),
    .synced_o (synced_o)
  );

  bpt_tick_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (half_period_i),
    .force_i  (resync),
    .tick_o   (tick)
  );

  bpt_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .force_i (resync),
    .phase_o (phase_o),
    .tx_o    (tx_strobe_o),
    .smp_o   (sample_strobe_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_strobe_o && sample_strobe_o)); // R3
endmodule

// File: tb/bit_phase_timer_tb.sv
module bit_phase_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hp = 16'd4;
  logic        rearm = 1'b0;
  logic        rx = 1'b1;
  logic        phase, txs, smps, synced;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  bit_phase_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .half_period_i(hp), .rearm_i(rearm),
    .rx_i(rx), .phase_o(phase), .tx_strobe_o(txs),
    .sample_strobe_o(smps), .synced_o(synced)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // negedges until the chosen strobe (0 = tx, 1 = sample) is seen
  task automatic count_to(input int which, output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if ((which == 0 && txs) || (which == 1 && smps)) return;
    end
    n = -1;
  endtask

  task automatic t_reset();
    int n;
    check("R8 phase", phase, 0);
    check("R8 tx", txs, 0);
    check("R8 smp", smps, 0);
    check("R8 synced", synced, 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_to(0, n);
    check("R8 first tx", n, 4);
  endtask

  task automatic t_period(input logic [15:0] v, input int h);
    int n;
    hp = v;
    count_to(0, n);
    count_to(1, n);
    check("R1 tx->smp", n, h);
    check("R4 phase at smp", phase, 0);
    count_to(0, n);
    check("R1 smp->tx", n, h);
    check("R3 phase at tx", phase, 1);
    @(negedge clk);
    if (h > 1) begin
      check("R3 tx one cycle", txs, 0);
      check("R2 phase held", phase, 1);
    end else begin
      check("R2 phase flips", phase, 0);
    end
  endtask

  task automatic t_resync();
    int n;
    hp = 16'd6;
    count_to(1, n);
    @(negedge clk); @(negedge clk);
    rx = 1'b0;
    @(negedge clk);
    check("R5 phase", phase, 1);
    check("R5 tx", txs, 1);
    check("R5 synced", synced, 1);
    count_to(1, n);
    check("R5 spacing", n, 6);
    rx = 1'b1;
  endtask

  task automatic t_ignored();
    int n;
    count_to(0, n);
    @(negedge clk); @(negedge clk);
    rx = 1'b0;
    @(negedge clk);
    check("R6 no tx", txs, 0);
    check("R6 phase", phase, 1);
    check("R6 synced", synced, 1);
    count_to(1, n);
    check("R6 spacing", n, 3);
    rx = 1'b1;
  endtask

  task automatic t_rearm();
    int n;
    count_to(0, n);
    @(negedge clk);
    rearm = 1'b1; rx = 1'b0;
    @(negedge clk);
    rearm = 1'b0;
    check("R7 cleared", synced, 0);
    check("R7 edge ignored", txs, 0);
    count_to(1, n);
    check("R7 spacing", n, 4);
    rx = 1'b1;
    t_resync();
  endtask

  task automatic t_lower();
    int n;
    hp = 16'd10;
    count_to(0, n);
    repeat (5) @(negedge clk);
    hp = 16'd2;
    count_to(1, n);
    check("R9 early end", n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_period(16'd4, 4);
    t_period(16'd7, 7);
    t_period(16'd1, 1);
    t_period(16'd0, 1);
    t_resync();
    t_ignored();
    t_rearm();
    t_lower();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule